// File: doc/BRIEF.md
# Embedded-Clock Serializer Framer

The block turns a 10-bit parallel word (one byte plus two control bits) into a 12-bit serial frame on a single line. Each frame begins with a clock bit of 1, carries the ten payload bits least significant first, and ends with a clock bit of 0. As a result, the line falls from 1 to 0 at every frame boundary, and a receiver can recover timing from the data alone. The block runs on a fast core clock. A bit-rate enable pulse, supplied by the surrounding logic at twelve times the word rate, advances the line by one bit. At a 40 MHz word rate this gives 480 Mbit/s of raw line rate, of which 400 Mbit/s is payload.

The parallel word is captured into a hold register on the edge of the word clock picked by a select input. It is moved into the shifter only at a frame boundary. A sync request, also sampled only at the boundary, replaces the payload with a fixed pattern that a receiver can lock to. A powerdown input stops framing and releases the line. An output enable releases the line while framing carries on underneath. The high-impedance state is modelled by a drive-enable flag, with the serial bit held at 0 while the line is not driven.

Top module: `ecs_framer`

## Requirements
- R1: After reset, and until the first bit-rate pulse, `drive_en_o` and `ser_o` are 0.
- R2: Each frame spans 12 bit-rate pulses, with one line bit per pulse. Frame bit 0 is 1, frame bits 1 to 10 carry payload bits 0 to 9 in that order, and frame bit 11 is 0.
- R3: While `bit_en_i` is low, the line bit does not change.
- R4: If `sync_i` is 1 at the frame boundary, the payload is five 1s followed by five 0s in sending order (payload value 10'h01F).
- R5: The payload of a frame is fixed at its boundary. Changes to `data_i`, to the hold register or to `sync_i` during the frame leave that frame's bits unchanged.
- R6: With `edge_sel_i` = 1, `data_i` is captured on a 0-to-1 transition of `word_clk_i`. With `edge_sel_i` = 0, it is captured on a 1-to-0 transition. A transition in the other direction captures nothing.
- R7: While `oe_i` is 0, `drive_en_o` and `ser_o` are 0, and the frame position keeps advancing.
- R8: While `pwrdn_ni` is 0, `drive_en_o` and `ser_o` are 0 and the frame is abandoned. The first bit-rate pulse after `pwrdn_ni` returns to 1 starts a new frame at its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate enable; one line bit per pulse |
| word_clk_i | input | 1 | Word clock, sampled in the core clock domain |
| edge_sel_i | input | 1 | 1 captures on the rising word-clock edge, 0 on the falling edge |
| data_i | input | 10 | Parallel word: byte plus two control bits |
| sync_i | input | 1 | Sends the lock pattern instead of data |
| pwrdn_ni | input | 1 | Powerdown, active low |
| oe_i | input | 1 | Line output enable |
| ser_o | output | 1 | Serial line bit (0 while not driven) |
| drive_en_o | output | 1 | 1 while the line is driven; 0 models high impedance |

## Verification
The bench sends random frames with word-clock edges of both directions inside each frame. A design that captured on both edges, or on the wrong one, would carry the wrong word in the following frame. A design that loaded the hold register straight into the shifter would corrupt the payload mid-frame. Random gaps in the bit-rate enable would show a shifter that advances without a pulse. The sync input is scrambled mid-frame, so sampling it outside the boundary would alter the frame on the line. Frames with the output enable low verify that the frame position stays aligned once the line returns. A powerdown in mid-frame must restart at a start bit rather than resume the abandoned frame.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int FRAME_OVH = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  function automatic logic [31:0] sync_payload(input int w);
    logic [31:0] p;
    p = '0;
    for (int k = 0; k < w / 2; k++) p[k] = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/ecs_edge_latch.sv
module ecs_edge_latch #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hold_o
);
  import ecs_pkg::*;

  logic wclk_q;
  logic rise, fall, take;

  assign rise = word_clk_i & ~wclk_q;
  assign fall = ~word_clk_i & wclk_q;
  assign take = (edge_sel_e'(edge_sel_i) == EDGE_RISE) ? rise : fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= 1'b0;
      hold_o <= '0;
    end else begin
      wclk_q <= word_clk_i;
      if (take) hold_o <= data_i;
    end
  end
endmodule

// File: rtl/ecs_frame_build.sv
module ecs_frame_build #(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + ecs_pkg::FRAME_OVH
) (
  input  logic               sync_i,
  input  logic [DATA_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int ONES = DATA_W / 2;

  logic [DATA_W-1:0] payload;

  for (genvar k = 0; k < DATA_W; k++) begin : g_pay
    if (k < ONES) begin : g_one
      assign payload[k] = sync_i | word_i[k];
    end else begin : g_zero
      assign payload[k] = ~sync_i & word_i[k];
    end
  end

  // bit 0 leaves first: start 1, payload LSB first, stop 0
  assign frame_o = {1'b0, payload, 1'b1};
endmodule

// File: rtl/ecs_shift_core.sv
module ecs_shift_core #(
  parameter int FRAME_W = 12,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_ni,
  input  logic               bit_en_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               line_bit_o,
  output logic               act_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] sh_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic boundary;
  assign boundary   = ~act_o | (cnt_o == LAST);
  assign line_bit_o = sh_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_o <= '0;
      sh_o  <= '0;
    end else if (!pwrdn_ni) begin
      act_o <= 1'b0;
      cnt_o <= '0;
      sh_o  <= '0;
    end else if (bit_en_i) begin
      if (boundary) begin
        sh_o  <= frame_i;
        cnt_o <= '0;
        act_o <= 1'b1;
      end else begin
        sh_o  <= {1'b0, sh_o[FRAME_W-1:1]};
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ecs_line_gate.sv
module ecs_line_gate (
  input  logic act_i,
  input  logic pwrdn_ni,
  input  logic oe_i,
  input  logic line_bit_i,
  output logic ser_o,
  output logic drive_en_o
);
  assign drive_en_o = act_i & pwrdn_ni & oe_i;
  assign ser_o      = drive_en_o & line_bit_i;
endmodule

// File: rtl/ecs_framer.sv
module ecs_framer #(
  parameter int DATA_W = 10,
  localparam int FRAME_W = DATA_W + ecs_pkg::FRAME_OVH,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              word_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_i,
  input  logic              pwrdn_ni,
  input  logic              oe_i,
  output logic              ser_o,
  output logic              drive_en_o
);
  logic [DATA_W-1:0]  hold;
  logic [FRAME_W-1:0] frame_nxt;
  logic [FRAME_W-1:0] frm_sh;
  logic [CNT_W-1:0]   frm_cnt;
  logic               frm_act;
  logic               line_bit;

  ecs_edge_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_clk_i (word_clk_i),
    .edge_sel_i (edge_sel_i),
    .data_i     (data_i),
    .hold_o     (hold)
  );

  ecs_frame_build #(.DATA_W(DATA_W)) u_build (
    .sync_i  (sync_i),
    .word_i  (hold),
    .frame_o (frame_nxt)
  );

  ecs_shift_core #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwrdn_ni   (pwrdn_ni),
    .bit_en_i   (bit_en_i),
    .frame_i    (frame_nxt),
    .line_bit_o (line_bit),
    .act_o      (frm_act),
    .cnt_o      (frm_cnt),
    .sh_o       (frm_sh)
  );

  ecs_line_gate u_gate (
    .act_i      (frm_act),
    .pwrdn_ni   (pwrdn_ni),
    .oe_i       (oe_i),
    .line_bit_i (line_bit),
    .ser_o      (ser_o),
    .drive_en_o (drive_en_o)
  );
endmodule

// File: rtl/ecs_framer_chk.sv
module ecs_framer_chk #(
  parameter int DATA_W = 10,
  localparam int FRAME_W = DATA_W + ecs_pkg::FRAME_OVH,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_en_i,
  input logic               sync_i,
  input logic               pwrdn_ni,
  input logic               oe_i,
  input logic               ser_o,
  input logic               drive_en_o,
  input logic               frm_act,
  input logic [CNT_W-1:0]   frm_cnt,
  input logic               line_bit,
  input logic [FRAME_W-1:0] frm_sh
);
  localparam logic [CNT_W-1:0]   LAST = CNT_W'(FRAME_W - 1);
  localparam logic [DATA_W-1:0]  SYNC_PAY = DATA_W'(ecs_pkg::sync_payload(DATA_W));
  localparam logic [FRAME_W-1:0] SYNC_FRM = {1'b0, SYNC_PAY, 1'b1};

  logic at_bnd;
  assign at_bnd = ~frm_act | (frm_cnt == LAST);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_act |-> !drive_en_o);

  // R2
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && pwrdn_ni && at_bnd) |=> (line_bit && frm_cnt == '0));

  // R2
  stop_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_act && frm_cnt == LAST) |-> !line_bit);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_cnt <= LAST);

  // R3
  hold_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && pwrdn_ni) |=> $stable(line_bit));

  // R4
  sync_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && pwrdn_ni && at_bnd && sync_i) |=> frm_sh == SYNC_FRM);

  // R7
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!drive_en_o && !ser_o));

  // R8
  pwrdn_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |=> !frm_act);

  // R8
  pwrdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |-> (!drive_en_o && !ser_o));
endmodule

bind ecs_framer ecs_framer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .sync_i     (sync_i),
  .pwrdn_ni   (pwrdn_ni),
  .oe_i       (oe_i),
  .ser_o      (ser_o),
  .drive_en_o (drive_en_o),
  .frm_act    (frm_act),
  .frm_cnt    (frm_cnt),
  .line_bit   (line_bit),
  .frm_sh     (frm_sh)
);

// File: tb/ecs_framer_bench.sv
`timescale 1ns/1ps
module ecs_framer_bench;
  localparam int DW = 10;
  localparam int FW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic          wclk = 1'b0;
  logic          esel = 1'b1;
  logic [DW-1:0] data = '0;
  logic          sync = 1'b0;
  logic          pwrdn_n = 1'b1;
  logic          oe = 1'b1;
  logic          ser, drv;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_hold = '0;

  always #2.5 clk = ~clk;

  ecs_framer #(.DATA_W(DW)) u_ecs_framer (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .word_clk_i(wclk),
    .edge_sel_i(esel), .data_i(data), .sync_i(sync), .pwrdn_ni(pwrdn_n),
    .oe_i(oe), .ser_o(ser), .drive_en_o(drv)
  );

  function automatic logic [FW-1:0] exp_frame(input logic sy, input logic [DW-1:0] w);
    return {1'b0, (sy ? 10'h01F : w), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en);
    bit_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  // pd_at >= 0 enters powerdown before that bit (must be < 3, before any word edge)
  task automatic run_frame(input logic sy, input logic oe_v, input logic sel,
                           input bit gaps, input int pd_at, input bit after_pd);
    logic [FW-1:0] cur;
    logic [DW-1:0] nxt, junk;
    nxt = exp_hold;
    junk = exp_hold;
    sync = sy;
    oe = oe_v;
    esel = sel;
    cur = exp_frame(sy, exp_hold);
    for (int i = 0; i < FW; i++) begin
      if (i == pd_at) begin
        pwrdn_n = 1'b0;
        for (int j = 0; j < 4; j++) begin
          step(1'b1);
          chk(!drv && !ser, "R8 powerdown line", {drv, ser}, 0);
        end
        pwrdn_n = 1'b1;
        return;
      end
      if (i == 3) begin
        nxt = DW'($urandom);
        data = nxt;
        wclk = 1'b1;
      end else if (i == 7) begin
        junk = DW'($urandom);
        data = junk;
        wclk = 1'b0;
      end
      if (i == 5) sync = 1'($urandom);
      step(1'b1);
      chk(drv == oe_v, "R7 drive flag", drv, oe_v);
      if (i == 0 && after_pd)
        chk(ser == oe_v, "R8 restart at start bit", ser, oe_v);
      else if (i == 0 || i == FW - 1)
        chk(ser == (oe_v & cur[i]), "R2 clock bit", ser, oe_v & cur[i]);
      else if (sy)
        chk(ser == (oe_v & cur[i]), "R4 sync payload", ser, oe_v & cur[i]);
      else
        chk(ser == (oe_v & cur[i]), "R5 R6 data payload", ser, oe_v & cur[i]);
      if (gaps) begin
        int n;
        logic prev;
        n = $urandom_range(0, 2);
        prev = ser;
        for (int g = 0; g < n; g++) begin
          step(1'b0);
          chk(ser == prev, "R3 line held without pulse", ser, prev);
        end
      end
    end
    exp_hold = sel ? nxt : junk;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    @(negedge clk);
    chk(!drv && !ser, "R1 reset line", {drv, ser}, 0);
    rst_n = 1'b1;
    step(1'b0);
    step(1'b0);
    chk(!drv && !ser, "R1 idle before first pulse", {drv, ser}, 0);

    // directed: first frame carries reset hold value, then sync, oe low, both edge kinds
    run_frame(1'b0, 1'b1, 1'b1, 1'b0, -1, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b0);
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b1, -1, 1'b0);
    run_frame(1'b0, 1'b1, 1'b1, 1'b0, 1, 1'b0);
    run_frame(1'b0, 1'b1, 1'b1, 1'b0, -1, 1'b1);
    run_frame(1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b0);

    for (int f = 0; f < 300; f++) begin
      logic sy, ov, sl;
      bit pd;
      sy = ($urandom_range(0, 4) == 0);
      ov = ($urandom_range(0, 5) != 0);
      sl = 1'($urandom);
      pd = ($urandom_range(0, 15) == 0);
      if (pd) begin
        run_frame(sy, ov, sl, 1'b1, $urandom_range(0, 2), 1'b0);
        run_frame(1'b0, 1'b1, sl, 1'b1, -1, 1'b1);
      end else begin
        run_frame(sy, ov, sl, 1'b1, -1, 1'b0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule